// File: doc/BRIEF.md
# First-Hit Address Selector

On every bunch crossing the selector receives one report from each of 32 front-end strip chips. Each chip has 64 strips. A report is a one-bit hit flag and the 6-bit address of the earliest strip hit in that chip during the crossing. The serial links from the chips are taken as already deserialised, so all flags and addresses arrive together as parallel words. The crossing's 12-bit bunch counter value arrives alongside them.

The block forwards at most 8 of the flagged reports, packed into 8 output slots. Slot 0 holds the flagged chip with the lowest index, and the following slots hold the next flagged chips in ascending index order. Each filled slot carries the source chip index and the strip address. The bunch counter value travels with the crossing. A saturation flag shows that hits were dropped.

The datapath has two register stages, so every crossing reaches the outputs with the same latency.

Top module: `fhs_selector`

## Requirements
- R1: While reset is high and after it is released, until the first crossing reaches the outputs, all outputs are zero: slot valids, chip fields, address fields, bunch tag and saturation flag.
- R2: Flagged chips fill slots in ascending chip index, with no gaps: slot 0 gets the lowest-numbered flagged chip. When more than 8 chips are flagged, only the 8 lowest-numbered ones are forwarded.
- R3: A filled slot j has `slot_vld[j]`=1. It carries the 5-bit source chip index in `slot_chip[j*5 +: 5]` and that chip's input address `hit_addr[i*6 +: 6]` in `slot_addr[j*6 +: 6]`.
- R4: A slot left empty has its valid bit at 0 and its chip and address fields at 0.
- R5: `sat` is 1 exactly when more than 8 flags were set in the crossing. With exactly 8 flags it is 0.
- R6: `out_bc` equals the `bc_num` value that was presented with the crossing shown on the slots.
- R7: Inputs presented before rising edge k appear on the outputs right after rising edge k+1. Back-to-back crossings do not interfere with each other.
- R8: The address input of a chip whose flag is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_vld | input | 32 | Hit flag per chip, bit i is chip i |
| hit_addr | input | 192 | Earliest strip address per chip, chip i at bits i*6+:6 |
| bc_num | input | 12 | Bunch counter value of the crossing |
| slot_vld | output | 8 | Slot filled flags |
| slot_chip | output | 40 | Source chip index per slot, slot j at bits j*5+:5 |
| slot_addr | output | 48 | Strip address per slot, slot j at bits j*6+:6 |
| out_bc | output | 12 | Bunch counter of the crossing on the slots |
| sat | output | 1 | More than 8 hits were present |

## Verification
The selector is driven with several families of flag patterns:
- All-clear and all-set crossings check the empty and the fully loaded outputs.
- A single flag walked over all 32 chips proves each chip reaches slot 0 with its own index and address.
- A pair of flags walked over the chip range checks the ascending order between two slots.
- Exactly 8 and exactly 9 flags separate the saturation threshold from the slot limit.
- Pseudo-random dense and sparse patterns exercise the priority cut and the packing.
- A crossing that flags one chip and sets every other address to all-ones shows that unflagged addresses are ignored.
- Two back-to-back crossings separate the fixed latency from stale or early data.

// File: rtl/fhs_pkg.sv
package fhs_pkg;
    localparam int N_CHIPS  = 32;
    localparam int N_SLOTS  = 8;
    localparam int STRIPS   = 64;
    localparam int BC_W     = 12;
    localparam int ADDR_W   = $clog2(STRIPS);
    localparam int CHIP_W   = $clog2(N_CHIPS);
    localparam int CNT_W    = $clog2(N_CHIPS + 1);

    typedef logic [ADDR_W-1:0] strip_addr_t;
    typedef logic [CHIP_W-1:0] chip_idx_t;
    typedef logic [CNT_W-1:0]  hit_cnt_t;

    typedef struct packed {
        logic        vld;
        chip_idx_t   chip;
        strip_addr_t addr;
    } slot_t;

    typedef struct packed {
        logic [N_CHIPS-1:0]         flags;
        strip_addr_t [N_CHIPS-1:0]  addrs;
        logic [BC_W-1:0]            bc;
    } crossing_t;

    function automatic slot_t empty_slot();
        slot_t s;
        s.vld  = 1'b0;
        s.chip = '0;
        s.addr = '0;
        return s;
    endfunction
endpackage

// File: rtl/fhs_capture.sv
module fhs_capture
    import fhs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CHIPS-1:0]        flags_in,
    input  logic [N_CHIPS*ADDR_W-1:0] addrs_in,
    input  logic [BC_W-1:0]           bc_in,
    output crossing_t                 xing_q
);
    crossing_t xing_d;

    always_comb begin
        xing_d.flags = flags_in;
        xing_d.bc    = bc_in;
        for (int i = 0; i < N_CHIPS; i++)
            xing_d.addrs[i] = addrs_in[i*ADDR_W +: ADDR_W];
    end

    always_ff @(posedge clk) begin
        if (rst) xing_q <= '0;
        else     xing_q <= xing_d;
    end
endmodule

// File: rtl/fhs_rank.sv
module fhs_rank
    import fhs_pkg::*;
(
    input  logic [N_CHIPS-1:0]            flags,
    output hit_cnt_t [N_CHIPS-1:0]        rank,
    output hit_cnt_t                      total
);
    always_comb begin
        rank[0] = '0;
        for (int i = 1; i < N_CHIPS; i++)
            rank[i] = rank[i-1] + hit_cnt_t'(flags[i-1]);
        total = rank[N_CHIPS-1] + hit_cnt_t'(flags[N_CHIPS-1]);
    end
endmodule

// File: rtl/fhs_pick.sv
module fhs_pick
    import fhs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CHIPS-1:0]        flags,
    input  strip_addr_t [N_CHIPS-1:0] addrs,
    input  hit_cnt_t [N_CHIPS-1:0]    rank,
    output slot_t [N_SLOTS-1:0]       slots
);
    for (genvar j = 0; j < N_SLOTS; j++) begin : g_slot
        always_comb begin
            slots[j] = empty_slot();
            for (int i = 0; i < N_CHIPS; i++) begin
                if (flags[i] && rank[i] == hit_cnt_t'(j)) begin
                    slots[j].vld  = 1'b1;
                    slots[j].chip = chip_idx_t'(i);
                    slots[j].addr = addrs[i];
                end
            end
        end

        a_r4_empty_zero: assert property (@(posedge clk) disable iff (rst)
            !slots[j].vld |-> (slots[j].chip == '0 && slots[j].addr == '0));

        if (j > 0) begin : g_order
            a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
                slots[j].vld |-> (slots[j-1].vld && slots[j].chip > slots[j-1].chip));
        end
    end
endmodule

// File: rtl/fhs_selector.sv
module fhs_selector
    import fhs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CHIPS-1:0]        hit_vld,
    input  logic [N_CHIPS*ADDR_W-1:0] hit_addr,
    input  logic [BC_W-1:0]           bc_num,
    output logic [N_SLOTS-1:0]        slot_vld,
    output logic [N_SLOTS*CHIP_W-1:0] slot_chip,
    output logic [N_SLOTS*ADDR_W-1:0] slot_addr,
    output logic [BC_W-1:0]           out_bc,
    output logic                      sat
);
    crossing_t             xing_q;
    hit_cnt_t [N_CHIPS-1:0] rank;
    hit_cnt_t              total;
    slot_t [N_SLOTS-1:0]   pick_d;
    slot_t [N_SLOTS-1:0]   slot_q;
    logic [BC_W-1:0]       bc_q;
    logic                  sat_q;

    fhs_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .flags_in (hit_vld),
        .addrs_in (hit_addr),
        .bc_in    (bc_num),
        .xing_q   (xing_q)
    );

    fhs_rank u_rank (
        .flags (xing_q.flags),
        .rank  (rank),
        .total (total)
    );

    fhs_pick u_pick (
        .clk   (clk),
        .rst   (rst),
        .flags (xing_q.flags),
        .addrs (xing_q.addrs),
        .rank  (rank),
        .slots (pick_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            bc_q   <= '0;
            sat_q  <= 1'b0;
        end else begin
            slot_q <= pick_d;
            bc_q   <= xing_q.bc;
            sat_q  <= (total > hit_cnt_t'(N_SLOTS));
        end
    end

    for (genvar j = 0; j < N_SLOTS; j++) begin : g_out
        assign slot_vld[j]                     = slot_q[j].vld;
        assign slot_chip[j*CHIP_W +: CHIP_W]   = slot_q[j].chip;
        assign slot_addr[j*ADDR_W +: ADDR_W]   = slot_q[j].addr;
    end
    assign out_bc = bc_q;
    assign sat    = sat_q;

    logic [1:0] settle;
    always_ff @(posedge clk) begin
        if (rst)                settle <= '0;
        else if (settle != 2'd2) settle <= settle + 2'd1;
    end

    a_r2_packed_low: assert property (@(posedge clk) disable iff (rst)
        ((slot_vld & (slot_vld + 1'b1)) == '0));

    a_r5_sat_full: assert property (@(posedge clk) disable iff (rst)
        sat |-> (&slot_vld));

    a_r6_bc_tag: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd2) |-> (out_bc == $past(bc_num, 2)));

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (slot_vld == '0 && out_bc == '0 && !sat));
endmodule

// File: tb/fhs_selector_test.sv
module fhs_selector_test;
    import fhs_pkg::*;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [N_CHIPS-1:0]        hit_vld = '0;
    logic [N_CHIPS*ADDR_W-1:0] hit_addr = '0;
    logic [BC_W-1:0]           bc_num = '0;
    logic [N_SLOTS-1:0]        slot_vld;
    logic [N_SLOTS*CHIP_W-1:0] slot_chip;
    logic [N_SLOTS*ADDR_W-1:0] slot_addr;
    logic [BC_W-1:0]           out_bc;
    logic                      sat;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    fhs_selector uut (
        .clk(clk), .rst(rst), .hit_vld(hit_vld), .hit_addr(hit_addr),
        .bc_num(bc_num), .slot_vld(slot_vld), .slot_chip(slot_chip),
        .slot_addr(slot_addr), .out_bc(out_bc), .sat(sat)
    );

    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Expected outputs computed from the requirements.
    typedef struct {
        logic [N_SLOTS-1:0]        v;
        logic [N_SLOTS*CHIP_W-1:0] c;
        logic [N_SLOTS*ADDR_W-1:0] a;
        logic [BC_W-1:0]           b;
        logic                      s;
    } exp_t;

    function automatic exp_t model(input logic [N_CHIPS-1:0] f,
                                   input logic [N_CHIPS*ADDR_W-1:0] ad,
                                   input logic [BC_W-1:0] b);
        exp_t e;
        int k = 0;
        e.v = '0; e.c = '0; e.a = '0; e.b = b;
        for (int i = 0; i < N_CHIPS; i++) begin
            if (f[i]) begin
                if (k < N_SLOTS) begin
                    e.v[k] = 1'b1;
                    e.c[k*CHIP_W +: CHIP_W] = i[CHIP_W-1:0];
                    e.a[k*ADDR_W +: ADDR_W] = ad[i*ADDR_W +: ADDR_W];
                end
                k++;
            end
        end
        e.s = (k > N_SLOTS);
        return e;
    endfunction

    task automatic check_out(input exp_t e);
        cmp("R2 slot valid order", 64'(slot_vld), 64'(e.v));
        cmp("R3/R4 chip fields",   64'(slot_chip), 64'(e.c));
        cmp("R3/R4 address fields",64'(slot_addr), 64'(e.a));
        cmp("R6 bunch tag",        64'(out_bc), 64'(e.b));
        cmp("R5 saturation",       64'(sat), 64'(e.s));
    endtask

    function automatic logic [N_CHIPS*ADDR_W-1:0] make_addr(input int seed);
        logic [N_CHIPS*ADDR_W-1:0] a;
        for (int i = 0; i < N_CHIPS; i++)
            a[i*ADDR_W +: ADDR_W] = ADDR_W'(i * 7 + seed * 13 + 5);
        return a;
    endfunction

    // R7: drive at a falling edge, two rising edges, sample at the next falling edge.
    task automatic run(input logic [N_CHIPS-1:0] f, input logic [N_CHIPS*ADDR_W-1:0] a,
                       input logic [BC_W-1:0] b);
        exp_t e;
        hit_vld = f; hit_addr = a; bc_num = b;
        e = model(f, a, b);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check_out(e);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        exp_t ea;
        exp_t eb;
        exp_t zero_e;
        logic [N_CHIPS-1:0] f;
        logic [N_CHIPS*ADDR_W-1:0] a;
        zero_e = model('0, '0, '0);

        // R1: reset state, with busy inputs held during reset.
        hit_vld = '1; hit_addr = make_addr(3); bc_num = 12'hABC;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out(zero_e);
        rst = 1'b0;
        hit_vld = '0;
        @(posedge clk); @(negedge clk);
        check_out(zero_e); // R1: first crossing not yet out

        // all clear and all set
        run('0, make_addr(1), 12'h001);
        run('1, make_addr(2), 12'h002);

        // walking single flag (R3)
        for (int i = 0; i < N_CHIPS; i++)
            run(N_CHIPS'(1) << i, make_addr(i), 12'(100 + i));

        // walking pair (R2)
        for (int i = 0; i < N_CHIPS - 1; i++)
            run((N_CHIPS'(1) << i) | (N_CHIPS'(1) << (N_CHIPS - 1 - i)), make_addr(i + 40), 12'(200 + i));

        // R5 threshold: exactly 8, exactly 9, at both ends
        run(32'h0000_00FF, make_addr(5), 12'h300);
        run(32'h0000_01FF, make_addr(6), 12'h301);
        run(32'hFF00_0000, make_addr(7), 12'h302);
        run(32'hFF80_0000, make_addr(8), 12'h303);
        run(32'h8888_8888, make_addr(9), 12'h304);
        run(32'h8888_8889, make_addr(9), 12'h305);

        // R8: only chip 3 flagged, every other address all-ones
        a = '1;
        a[3*ADDR_W +: ADDR_W] = 6'd17;
        run(32'h0000_0008, a, 12'h400);
        cmp("R8 unflagged address ignored", 64'(slot_addr), 64'(17));

        // pseudo-random dense and sparse patterns (R2, R3, R5)
        for (int t = 0; t < 200; t++) begin
            rng = next_rng(rng);
            f = rng;
            if (t % 2 == 1) f = f & next_rng(rng) & next_rng(next_rng(rng));
            rng = next_rng(rng);
            for (int i = 0; i < N_CHIPS; i++) begin
                rng = next_rng(rng);
                a[i*ADDR_W +: ADDR_W] = rng[ADDR_W-1:0];
            end
            run(f, a, rng[BC_W-1:0]);
        end

        // R7: back-to-back crossings
        ea = model(32'h0000_F00F, make_addr(11), 12'h5A5);
        eb = model(32'hF0F0_0001, make_addr(12), 12'h7E7);
        hit_vld = 32'h0000_F00F; hit_addr = make_addr(11); bc_num = 12'h5A5;
        @(posedge clk); @(negedge clk);
        hit_vld = 32'hF0F0_0001; hit_addr = make_addr(12); bc_num = 12'h7E7;
        @(posedge clk); @(negedge clk);
        check_out(ea); // R7 first crossing
        hit_vld = '0;
        @(posedge clk); @(negedge clk);
        check_out(eb); // R7 second crossing

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule